// File: doc/BRIEF.md
# Recovering Store Forwarding Matcher

A load that was allowed to fail without trapping leaves an entry in a deferred-exception status table. The entry holds the failing load's effective address, the destination register it was meant to fill, and a bit that says whether that register is integer or floating-point. When a later store writes to exactly that address, the value it carries is the data the load should have returned. This block watches the store stream. On every accepted store it searches the live table entries for an address match. On a hit it repairs the stale destination register by forwarding the store data into it. It also asks the data cache to flush and invalidate the line that holds the address.

The search is associative and combinational in the cycle the store is presented. The winning entry is the one with the lowest index. Forwarding then runs one register write per cycle, in 32-bit words, for as many words as the store size implies. While forwarding is in progress, a busy output tells the store source to hold off. The table contents, the cache and both register files live outside the block.

Top module: `store_fwd_matcher`

## Requirements
- R1: After reset, busy, invReq, intWe and fpWe are all low.
- R2: An entry takes part in the search only if ctlValid is high, its entValid bit is set, its index is below implCount, and its entAddr equals storeAddr on every bit. If any of these conditions fails, that entry does not produce a hit.
- R3: When several entries qualify, only the lowest-index entry is used. It supplies the destination register and the file select, and the others have no effect.
- R4: On a hit, invReq is high for exactly one cycle, the cycle after the store is accepted. In that cycle invAddr equals storeAddr with its low log2(LINE_BYTES) bits cleared (bits [4:0] at the default of 32).
- R5: The storeSize code sets the number of 32-bit words written: 0 (byte), 1 (half), 2 (word) and 5 to 7 give one word, 3 gives two and 4 gives four. Word k carries srcWords[k] and goes to register entDest+k, modulo 2^REG_W. The writes occur on consecutive cycles starting the cycle after acceptance.
- R6: For storeSize 0 the forwarded word is srcWords[0] & 0xFF. For storeSize 1 it is srcWords[0] & 0xFFFF. Other sizes forward the words unmasked.
- R7: The winning entry's entFloat bit alone selects the file. A value of 1 writes through fpWe/fpWaddr/fpWdata and 0 writes through intWe/intWaddr/intWdata. Both ports are never written in the same cycle.
- R8: A store is accepted only on a rising edge where storeValid is high and busy is low. busy is high in every forwarding write cycle and low again the cycle after the last write. A store presented while busy is high is ignored.
- R9: An accepted store that matches no entry causes no register write and no invReq, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| storeValid | input | 1 | A store is presented this cycle |
| storeAddr | input | ADDR_W | Store effective address |
| storeSize | input | 3 | Store size code (see R5) |
| srcWords | input | MAX_WORDS x DATA_W | Store source register values, word k from source register base+k |
| ctlValid | input | 1 | Table control valid; when low nothing matches |
| implCount | input | clog2(N_ENTRIES+1) | Number of implemented table entries |
| entValid | input | N_ENTRIES | Per-entry valid bit |
| entFloat | input | N_ENTRIES | Per-entry destination file select (1 = floating-point) |
| entDest | input | N_ENTRIES x REG_W | Per-entry destination register number |
| entAddr | input | N_ENTRIES x ADDR_W | Per-entry recorded load address |
| busy | output | 1 | Forwarding in progress; new stores are not accepted |
| invReq | output | 1 | One-cycle flush-and-invalidate request |
| invAddr | output | ADDR_W | Line-aligned address for the invalidate |
| intWe | output | 1 | Integer register file write enable |
| intWaddr | output | REG_W | Integer register file write address |
| intWdata | output | DATA_W | Integer register file write data |
| fpWe | output | 1 | Floating-point register file write enable |
| fpWaddr | output | REG_W | Floating-point register file write address |
| fpWdata | output | DATA_W | Floating-point register file write data |

## Verification
The bench sets up two qualifying entries with different destinations. A priority encoder that let the highest match win would then write the wrong register or the wrong file. Entries that match but sit at or above implCount, that have a clear valid bit, or that are masked by a low ctlValid must produce no write and no invalidate. A design that skipped any of these gates would repair registers that were never deferred. A quad store aimed at destination 62 checks the wrap to registers 0 and 1. Byte and halfword stores carrying 0xDEADBEEF expose a missing mask. A second matching store is held up during a multi-word forward to confirm it is dropped and does not splice into the running sequence or retrigger the invalidate.

// File: rtl/store_fwd_pkg.sv
`timescale 1ns/1ps
package store_fwd_pkg;

  localparam logic [2:0] SZ_BYTE = 3'd0;
  localparam logic [2:0] SZ_HALF = 3'd1;
  localparam logic [2:0] SZ_WORD = 3'd2;
  localparam logic [2:0] SZ_DBL  = 3'd3;
  localparam logic [2:0] SZ_QUAD = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a hit this edge
    logic step;   // a forwarding write is on the ports this cycle
  } fwd_strb_t;

  function automatic int wordsFor(input logic [2:0] sz);
    case (sz)
      SZ_DBL:  return 2;
      SZ_QUAD: return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/store_fwd_match.sv
`timescale 1ns/1ps
module store_fwd_match #(
  parameter int N_ENTRIES = 4,
  parameter int ADDR_W    = 32,
  localparam int CNT_W    = $clog2(N_ENTRIES + 1),
  localparam int HIT_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                             ctlValid,
  input  logic [CNT_W-1:0]                 implCount,
  input  logic [N_ENTRIES-1:0]             entValid,
  input  logic [N_ENTRIES-1:0][ADDR_W-1:0] entAddr,
  input  logic [ADDR_W-1:0]                storeAddr,
  output logic                             hit,
  output logic [HIT_W-1:0]                 hitIdx
);

  logic [N_ENTRIES-1:0] cand;

  // one comparator per table entry
  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
    assign cand[i] = ctlValid && entValid[i] &&
                     (implCount > CNT_W'(i)) &&
                     (entAddr[i] == storeAddr);
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit    = |cand;
    hitIdx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (cand[i]) hitIdx = HIT_W'(i);
    end
  end

endmodule

// File: rtl/store_fwd_ctrl.sv
`timescale 1ns/1ps
module store_fwd_ctrl
  import store_fwd_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             storeValid,
  input  logic             hit,
  input  logic [IDX_W-1:0] lastIdxIn,
  output logic             busy,
  output fwd_strb_t        strb,
  output logic [IDX_W-1:0] wordIdx
);

  typedef enum logic { ST_IDLE, ST_FWD } ctrl_st_t;

  ctrl_st_t         state;
  logic [IDX_W-1:0] lastIdx;

  always_comb begin
    strb.load = storeValid && (state == ST_IDLE) && hit;
    strb.step = (state == ST_FWD);
    busy      = (state == ST_FWD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
      lastIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strb.load) begin
            state   <= ST_FWD;
            wordIdx <= '0;
            lastIdx <= lastIdxIn;
          end
        end
        ST_FWD: begin
          if (wordIdx == lastIdx) state <= ST_IDLE;
          else                    wordIdx <= wordIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/store_fwd_dp.sv
`timescale 1ns/1ps
module store_fwd_dp
  import store_fwd_pkg::*;
#(
  parameter int N_ENTRIES  = 4,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int REG_W      = 6,
  parameter int MAX_WORDS  = 4,
  parameter int LINE_BYTES = 32,
  localparam int HIT_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int IDX_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
  localparam int LINE_OFF  = $clog2(LINE_BYTES)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  fwd_strb_t                           strb,
  input  logic [IDX_W-1:0]                    wordIdx,
  input  logic [ADDR_W-1:0]                   storeAddr,
  input  logic [2:0]                          storeSize,
  input  logic [MAX_WORDS-1:0][DATA_W-1:0]    srcWords,
  input  logic [HIT_W-1:0]                    hitIdx,
  input  logic [N_ENTRIES-1:0]                entFloat,
  input  logic [N_ENTRIES-1:0][REG_W-1:0]     entDest,
  output logic [IDX_W-1:0]                    lastIdx,
  output logic                                invReq,
  output logic [ADDR_W-1:0]                   invAddr,
  output logic                                intWe,
  output logic [REG_W-1:0]                    intWaddr,
  output logic [DATA_W-1:0]                   intWdata,
  output logic                                fpWe,
  output logic [REG_W-1:0]                    fpWaddr,
  output logic [DATA_W-1:0]                   fpWdata
);

  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'((64'd1 << LINE_OFF) - 64'd1);

  logic [MAX_WORDS-1:0][DATA_W-1:0] maskedWords;
  logic [MAX_WORDS-1:0][DATA_W-1:0] dataQ;
  logic [REG_W-1:0]                 destBase;
  logic                             isFloat;
  logic [REG_W-1:0]                 curAddr;
  logic [DATA_W-1:0]                curData;
  int                               wordCnt;

  // size code to last word index, clamped to the port width
  always_comb begin
    wordCnt = wordsFor(storeSize);
    if (wordCnt > MAX_WORDS) wordCnt = MAX_WORDS;
    lastIdx = IDX_W'(wordCnt - 1);
  end

  // narrow stores forward only their low bytes
  always_comb begin
    maskedWords = srcWords;
    case (storeSize)
      SZ_BYTE: maskedWords[0] = srcWords[0] & DATA_W'(32'h0000_00ff);
      SZ_HALF: maskedWords[0] = srcWords[0] & DATA_W'(32'h0000_ffff);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ    <= '0;
      destBase <= '0;
      isFloat  <= 1'b0;
      invReq   <= 1'b0;
      invAddr  <= '0;
    end else begin
      invReq <= strb.load;
      if (strb.load) begin
        dataQ    <= maskedWords;
        destBase <= entDest[hitIdx];
        isFloat  <= entFloat[hitIdx];
        invAddr  <= storeAddr & ~LINE_MASK;
      end
    end
  end

  assign curAddr = destBase + REG_W'(wordIdx);
  assign curData = dataQ[wordIdx];

  always_comb begin
    intWe    = strb.step && !isFloat;
    fpWe     = strb.step && isFloat;
    intWaddr = curAddr;
    fpWaddr  = curAddr;
    intWdata = curData;
    fpWdata  = curData;
  end

endmodule

// File: rtl/store_fwd_matcher.sv
`timescale 1ns/1ps
module store_fwd_matcher
  import store_fwd_pkg::*;
#(
  parameter int N_ENTRIES  = 4,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int REG_W      = 6,
  parameter int MAX_WORDS  = 4,
  parameter int LINE_BYTES = 32,
  localparam int CNT_W     = $clog2(N_ENTRIES + 1),
  localparam int HIT_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int IDX_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             storeValid,
  input  logic [ADDR_W-1:0]                storeAddr,
  input  logic [2:0]                       storeSize,
  input  logic [MAX_WORDS-1:0][DATA_W-1:0] srcWords,
  input  logic                             ctlValid,
  input  logic [CNT_W-1:0]                 implCount,
  input  logic [N_ENTRIES-1:0]             entValid,
  input  logic [N_ENTRIES-1:0]             entFloat,
  input  logic [N_ENTRIES-1:0][REG_W-1:0]  entDest,
  input  logic [N_ENTRIES-1:0][ADDR_W-1:0] entAddr,
  output logic                             busy,
  output logic                             invReq,
  output logic [ADDR_W-1:0]                invAddr,
  output logic                             intWe,
  output logic [REG_W-1:0]                 intWaddr,
  output logic [DATA_W-1:0]                intWdata,
  output logic                             fpWe,
  output logic [REG_W-1:0]                 fpWaddr,
  output logic [DATA_W-1:0]                fpWdata
);

  logic             hit;
  logic [HIT_W-1:0] hitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] wordIdx;
  fwd_strb_t        strb;

  store_fwd_match #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) match_i (
    .ctlValid (ctlValid),
    .implCount(implCount),
    .entValid (entValid),
    .entAddr  (entAddr),
    .storeAddr(storeAddr),
    .hit      (hit),
    .hitIdx   (hitIdx)
  );

  store_fwd_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .storeValid(storeValid),
    .hit       (hit),
    .lastIdxIn (lastIdx),
    .busy      (busy),
    .strb      (strb),
    .wordIdx   (wordIdx)
  );

  store_fwd_dp #(
    .N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .REG_W(REG_W), .MAX_WORDS(MAX_WORDS), .LINE_BYTES(LINE_BYTES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wordIdx  (wordIdx),
    .storeAddr(storeAddr),
    .storeSize(storeSize),
    .srcWords (srcWords),
    .hitIdx   (hitIdx),
    .entFloat (entFloat),
    .entDest  (entDest),
    .lastIdx  (lastIdx),
    .invReq   (invReq),
    .invAddr  (invAddr),
    .intWe    (intWe),
    .intWaddr (intWaddr),
    .intWdata (intWdata),
    .fpWe     (fpWe),
    .fpWaddr  (fpWaddr),
    .fpWdata  (fpWdata)
  );

endmodule

// File: rtl/store_fwd_chk.sv
`timescale 1ns/1ps
module store_fwd_chk #(
  parameter int REG_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             invReq,
  input logic             intWe,
  input logic [REG_W-1:0] intWaddr,
  input logic             fpWe,
  input logic [REG_W-1:0] fpWaddr
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!busy && !invReq && !intWe && !fpWe));

  // R7
  one_file_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(intWe && fpWe));

  // R8
  write_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intWe || fpWe) |-> busy);

  // R8
  busy_starts_with_inv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !$past(busy)) |-> invReq);

  // R4
  inv_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    invReq |=> !invReq);

  // R4
  inv_with_first_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    invReq |-> (intWe || fpWe));

  // R5
  int_addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intWe && !invReq) |-> ($past(intWe) && intWaddr == $past(intWaddr) + 1'b1));

  // R5
  fp_addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fpWe && !invReq) |-> ($past(fpWe) && fpWaddr == $past(fpWaddr) + 1'b1));

endmodule

bind store_fwd_matcher store_fwd_chk #(.REG_W(REG_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .invReq  (invReq),
  .intWe   (intWe),
  .intWaddr(intWaddr),
  .fpWe    (fpWe),
  .fpWaddr (fpWaddr)
);

// File: tb/store_fwd_matcher_tb_top.sv
`timescale 1ns/1ps
module store_fwd_matcher_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic             storeValid = 1'b0;
  logic [31:0]      storeAddr = '0;
  logic [2:0]       storeSize = '0;
  logic [3:0][31:0] srcWords = '0;
  logic             ctlValid = 1'b0;
  logic [2:0]       implCount = '0;
  logic [3:0]       tValid = '0;
  logic [3:0]       tFloat = '0;
  logic [3:0][5:0]  tDest = '0;
  logic [3:0][31:0] tAddr = '0;

  logic        busy, invReq, intWe, fpWe;
  logic [31:0] invAddr, intWdata, fpWdata;
  logic [5:0]  intWaddr, fpWaddr;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  store_fwd_matcher dut_i (
    .clk(clk), .rstN(rstN), .storeValid(storeValid), .storeAddr(storeAddr),
    .storeSize(storeSize), .srcWords(srcWords), .ctlValid(ctlValid),
    .implCount(implCount), .entValid(tValid), .entFloat(tFloat),
    .entDest(tDest), .entAddr(tAddr), .busy(busy), .invReq(invReq),
    .invAddr(invAddr), .intWe(intWe), .intWaddr(intWaddr), .intWdata(intWdata),
    .fpWe(fpWe), .fpWaddr(fpWaddr), .fpWdata(fpWdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int expHit(input logic [31:0] a);
    for (int i = 0; i < 4; i++)
      if (ctlValid && tValid[i] && (i < int'(implCount)) && tAddr[i] == a) return i;
    return -1;
  endfunction

  function automatic int expWords(input logic [2:0] sz);
    if (sz == 3'd3) return 2;
    if (sz == 3'd4) return 4;
    return 1;
  endfunction

  function automatic logic [31:0] expWord(input logic [2:0] sz, input int k,
                                          input logic [3:0][31:0] w);
    if (k == 0 && sz == 3'd0) return w[0] & 32'h0000_00ff;
    if (k == 0 && sz == 3'd1) return w[0] & 32'h0000_ffff;
    return w[k];
  endfunction

  function automatic logic [31:0] poolAddr(input int k);
    return 32'h8000_0000 + 32'(k) * 32'h0000_0104;
  endfunction

  // checks one cycle of forwarding for the expected entry
  task automatic checkWrite(input int hi, input int k, input logic [2:0] sz,
                            input logic [31:0] a, input logic [3:0][31:0] w);
    logic       isF;
    logic [5:0] ed;
    logic [5:0] actAddr;
    logic [31:0] actData;
    isF = tFloat[hi];
    ed  = tDest[hi] + 6'(k);
    actAddr = isF ? fpWaddr : intWaddr;
    actData = isF ? fpWdata : intWdata;
    check(intWe == !isF, "R7", "intWe", 64'(intWe), 64'(!isF));
    check(fpWe == isF,   "R7", "fpWe",  64'(fpWe),  64'(isF));
    check(actAddr == ed, "R5", "dest reg", 64'(actAddr), 64'(ed));
    check(actData == expWord(sz, k, w), "R6", "data", 64'(actData), 64'(expWord(sz, k, w)));
    check(invReq == (k == 0), "R4", "invReq", 64'(invReq), 64'(k == 0));
    if (k == 0)
      check(invAddr == (a & ~32'h1f), "R4", "invAddr", 64'(invAddr), 64'(a & ~32'h1f));
    check(busy == 1'b1, "R8", "busy during write", 64'(busy), 64'd1);
  endtask

  task automatic runStore(input logic [31:0] a, input logic [2:0] sz,
                          input logic [3:0][31:0] w, input string req);
    int hi;
    @(negedge clk);
    storeAddr = a; storeSize = sz; srcWords = w; storeValid = 1'b1;
    hi = expHit(a);
    @(negedge clk);
    storeValid = 1'b0;
    if (hi < 0) begin
      check(!intWe && !fpWe, req, "no write on miss", 64'({intWe, fpWe}), 64'd0);
      check(!invReq && !busy, req, "no inv/busy on miss", 64'({invReq, busy}), 64'd0);
    end else begin
      for (int k = 0; k < expWords(sz); k++) begin
        checkWrite(hi, k, sz, a, w);
        @(negedge clk);
      end
      check(!busy && !intWe && !fpWe, "R8", "idle after last write",
            64'({busy, intWe, fpWe}), 64'd0);
    end
  endtask

  function automatic logic [3:0][31:0] rndWords();
    logic [3:0][31:0] w;
    for (int i = 0; i < 4; i++) w[i] = $urandom;
    return w;
  endfunction

  task automatic setAll(input logic [3:0] v, input logic [3:0] f);
    ctlValid = 1'b1; implCount = 3'd4; tValid = v; tFloat = f;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    logic [3:0][31:0] w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !invReq && !intWe && !fpWe, "R1", "reset outputs",
          64'({busy, invReq, intWe, fpWe}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !invReq && !intWe && !fpWe, "R1", "after reset",
          64'({busy, invReq, intWe, fpWe}), 64'd0);

    for (int i = 0; i < 4; i++) begin
      tAddr[i] = poolAddr(i);
      tDest[i] = 6'(8 * i + 3);
    end

    // R3: entries 1 and 3 share an address; entry 1 must win
    tAddr[3] = poolAddr(1);
    setAll(4'b1010, 4'b0010);
    tDest[3] = 6'd50;
    runStore(poolAddr(1), 3'd2, rndWords(), "R3");
    setAll(4'b1010, 4'b1000);
    runStore(poolAddr(1), 3'd3, rndWords(), "R3");

    // R2: match at index 3 but implCount is 3
    tAddr[3] = poolAddr(3);
    setAll(4'b1000, 4'b0000);
    implCount = 3'd3;
    runStore(poolAddr(3), 3'd2, rndWords(), "R2");
    // R2: control invalid
    setAll(4'b1111, 4'b0000);
    ctlValid = 1'b0;
    runStore(poolAddr(0), 3'd2, rndWords(), "R2");
    // R2: entry valid bit clear
    setAll(4'b1101, 4'b0000);
    runStore(poolAddr(1), 3'd2, rndWords(), "R2");
    // R9: address not in the table
    setAll(4'b1111, 4'b0101);
    runStore(32'h1234_5678, 3'd4, rndWords(), "R9");

    // R5 quad with destination wrap 62,63,0,1
    setAll(4'b0001, 4'b0000);
    tDest[0] = 6'd62;
    runStore(poolAddr(0), 3'd4, rndWords(), "R5");
    // R5 size code 6 acts as one unmasked word
    w = rndWords(); w[0] = 32'hdead_beef;
    runStore(poolAddr(0), 3'd6, w, "R5");
    // R6 byte and half masking, float destination
    setAll(4'b0001, 4'b0001);
    runStore(poolAddr(0), 3'd0, w, "R6");
    runStore(poolAddr(0), 3'd1, w, "R6");

    // R8: second store presented during a quad forward is ignored
    setAll(4'b0011, 4'b0000);
    tDest[0] = 6'd10; tDest[1] = 6'd40;
    w = rndWords();
    @(negedge clk);
    storeAddr = poolAddr(0); storeSize = 3'd4; srcWords = w; storeValid = 1'b1;
    @(negedge clk);
    storeValid = 1'b0;
    checkWrite(0, 0, 3'd4, poolAddr(0), w);
    @(negedge clk);
    checkWrite(0, 1, 3'd4, poolAddr(0), w);
    storeAddr = poolAddr(1); storeSize = 3'd2; storeValid = 1'b1;
    @(negedge clk);
    storeValid = 1'b0;
    check(intWaddr == 6'd12 && !invReq, "R8", "stalled store ignored (addr)",
          64'(intWaddr), 64'd12);
    check(intWdata == w[2], "R8", "stalled store ignored (data)", 64'(intWdata), 64'(w[2]));
    @(negedge clk);
    check(intWaddr == 6'd13 && intWe, "R8", "last write", 64'(intWaddr), 64'd13);
    @(negedge clk);
    repeat (2) begin
      check(!busy && !intWe && !fpWe && !invReq, "R8", "nothing after stall",
            64'({busy, intWe, fpWe, invReq}), 64'd0);
      @(negedge clk);
    end

    // constrained random mix
    for (int n = 0; n < 200; n++) begin
      ctlValid  = ($urandom % 10) != 0;
      implCount = 3'($urandom % 5);
      tValid    = 4'($urandom);
      tFloat    = 4'($urandom);
      for (int i = 0; i < 4; i++) begin
        tAddr[i] = poolAddr($urandom % 5);
        tDest[i] = 6'($urandom);
      end
      runStore(poolAddr($urandom % 6), 3'($urandom % 8), rndWords(), "R9");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule